// File: doc/BRIEF.md
# Stopwatch Counter with Lap Capture

This block keeps a three-digit BCD stopwatch count. The digits are hundredths, tenths and seconds. A host reads the count over a 4-bit data path, one nibble per read. The hundredths nibble must be read first. That read freezes a copy of the two upper digits, so the whole 12-bit value stays consistent while the host fetches the remaining nibbles one at a time.

A lap pulse copies the running count into a hold buffer, and reads are served from that buffer until the host has fetched it. A renewal flag tells the host that a lap overwrote the buffer partway through a read sequence, which means the nibbles it collected may be stale. The block raises an interrupt flag once per second, on each carry into the seconds digit. The stopwatch clear does not remove this flag; only an explicit acknowledge does. A carry-request flag warns that a lap was taken while a seconds carry was still waiting for its interrupt to be serviced. Software can then add that carry to the lap time itself.

Top module: `sw_lap_counter`

## Requirements
- R1: After reset, every digit, flag and the hold buffer is zero. Each cycle with `tick_i` high advances the count by one in BCD. The hundredths digit is bits 3:0 and goes 9 to 0 with a carry into the tenths digit (bits 7:4). The tenths digit carries into the seconds digit (bits 11:8), which wraps from 9 to 0, so 999 is followed by 000.
- R2: A tick that carries the tenths digit from 9 into the seconds digit sets the interrupt flag, and `irq_o` shows that flag.
- R3: `clr_i` zeroes the count, empties the hold buffer and drops the held state. It takes priority over a tick and over a lap in the same cycle. It leaves the interrupt flag unchanged.
- R4: `irq_ack_i` clears the interrupt flag. If a new seconds carry happens in the same cycle, the flag stays set.
- R5: A lap pulse captures the count as it stood before that edge and places the block in the held state. While held, a read of address 0 returns the buffer instead of the live count. A read of address 2 leaves the held state, unless the renewal flag is set or a lap occurs in that same cycle.
- R6: A read of address 0 returns bits 3:0 of the source and latches bits 11:4 of the source into a shadow. Reads of address 1 and address 2 return shadow bits 7:4 and shadow bits 11:8. The shadow changes only on an address-0 read. Address 3 reads as zero.
- R7: `renew_o` is set by a lap that comes after an address-0 read, up to and including the address-2 read that closes the sequence. A lap in the same cycle as the address-0 read also sets it. The next address-0 read clears it.
- R8: `carry_o` is set by a lap that occurs while the interrupt flag is pending, or in the same cycle as a seconds carry.
- R9: A cycle with `carry_clr_i` high clears `carry_o`, unless a setting lap occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one pulse per hundredth |
| lap_i | input | 1 | Lap capture pulse |
| clr_i | input | 1 | Stopwatch clear |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | 2 | Nibble select: 0 low, 1 middle, 2 top |
| rd_data_o | output | 4 | Read data nibble |
| irq_ack_i | input | 1 | Clears the interrupt flag |
| carry_clr_i | input | 1 | Write-one clear of the carry-request flag |
| irq_o | output | 1 | Interrupt flag (seconds carry pending) |
| renew_o | output | 1 | Hold buffer renewed during a read sequence |
| carry_o | output | 1 | Lap taken with a seconds carry pending |

## Verification
Some properties are checked on every cycle. Digits stay within BCD range. A clear zeroes the count while the interrupt flag persists. The shadow holds still except on a low-nibble read. A pending flag combined with a lap always raises the carry request. The renewal flag drops on a low-nibble read that has no lap. Other behaviours appear only across the bench's scenarios: nibble values as the count advances, the boundary from 999 to 000, a read sequence broken by a lap, release of the held state, and a lap taken in the same cycle as a seconds carry.

// File: rtl/sw_lap_counter.sv
module sw_lap_counter #(
  parameter int NIB     = 4,
  parameter int SEC_MAX = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           lap_i,
  input  logic           clr_i,
  input  logic           rd_i,
  input  logic [1:0]     rd_addr_i,
  output logic [NIB-1:0] rd_data_o,
  input  logic           irq_ack_i,
  input  logic           carry_clr_i,
  output logic           irq_o,
  output logic           renew_o,
  output logic           carry_o
);
  localparam int CW = 3 * NIB;

  logic [NIB-1:0]  d0, d1, d2;
  logic [CW-1:0]   live, hold, src;
  logic [CW-NIB-1:0] shadow;
  logic            held, seq_open, irq_flag, renew, carry;
  logic            run, c0, c1, lap, rd_lo, rd_hi;

  assign run   = tick_i & ~clr_i;
  assign c0    = run & (d0 == NIB'(9));
  assign c1    = c0 & (d1 == NIB'(9));
  assign lap   = lap_i & ~clr_i;
  assign rd_lo = rd_i & (rd_addr_i == 2'd0);
  assign rd_hi = rd_i & (rd_addr_i == 2'd2);
  assign live  = {d2, d1, d0};
  assign src   = held ? hold : live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d0 <= '0;
      d1 <= '0;
      d2 <= '0;
    end else if (clr_i) begin
      d0 <= '0;
      d1 <= '0;
      d2 <= '0;
    end else if (run) begin
      d0 <= c0 ? '0 : d0 + 1'b1;
      if (c0) d1 <= c1 ? '0 : d1 + 1'b1;
      if (c1) d2 <= (d2 == NIB'(SEC_MAX)) ? '0 : d2 + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold <= '0;
      held <= 1'b0;
    end else if (clr_i) begin
      hold <= '0;
      held <= 1'b0;
    end else if (lap) begin
      hold <= live;
      held <= 1'b1;
    end else if (rd_hi && !renew) begin
      held <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow   <= '0;
      seq_open <= 1'b0;
      renew    <= 1'b0;
    end else begin
      if (rd_lo) shadow <= src[CW-1:NIB];
      if (rd_lo)      seq_open <= 1'b1;
      else if (rd_hi) seq_open <= 1'b0;
      if (rd_lo)                 renew <= lap;
      else if (lap && seq_open)  renew <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_flag <= 1'b0;
      carry    <= 1'b0;
    end else begin
      if (c1)             irq_flag <= 1'b1;
      else if (irq_ack_i) irq_flag <= 1'b0;
      if (lap && (c1 || irq_flag)) carry <= 1'b1;
      else if (carry_clr_i)        carry <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_i) begin
      case (rd_addr_i)
        2'd0:    rd_data_o = src[NIB-1:0];
        2'd1:    rd_data_o = shadow[NIB-1:0];
        2'd2:    rd_data_o = shadow[2*NIB-1:NIB];
        default: rd_data_o = '0;
      endcase
    end
  end

  assign irq_o   = irq_flag;
  assign renew_o = renew;
  assign carry_o = carry;

  p_bcd_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d0 <= NIB'(9) && d1 <= NIB'(9) && d2 <= NIB'(SEC_MAX));

  p_clear_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> live == '0 && !held);

  p_clear_keeps_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_ack_i |=> irq_o);

  p_shadow_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_lo |=> $stable(shadow));

  p_renew_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo && !lap_i |=> !renew_o);

  p_carry_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lap_i && !clr_i && irq_o |=> carry_o);

  p_carry_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_clr_i && !lap_i |=> !carry_o);
endmodule

// File: tb/sw_lap_counter_tb.sv
module sw_lap_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, lap = 1'b0, clr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [3:0] rdata;
  logic       ack = 1'b0, cclr = 1'b0;
  logic       irq, renew, carry;

  int vectors = 0;
  int fails   = 0;
  int cnt     = 0;
  bit done    = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  sw_lap_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .lap_i(lap), .clr_i(clr),
    .rd_i(rd), .rd_addr_i(addr), .rd_data_o(rdata), .irq_ack_i(ack),
    .carry_clr_i(cclr), .irq_o(irq), .renew_o(renew), .carry_o(carry)
  );

  function automatic logic [3:0] dig(int v, int k);
    int p = (k == 0) ? 1 : (k == 1) ? 10 : 100;
    return 4'((v / p) % 10);
  endfunction

  task automatic chk(logic got, logic exp, string tag);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (rd && exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: got %0d expected %0d", t, rdata, e);
      end
    end
  end

  task automatic rd_nib(logic [1:0] a, logic [3:0] e, string tag);
    rd = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      cnt = (cnt + 1) % 1000;
    end
  endtask

  task automatic pulse_lap();
    lap = 1'b1; @(negedge clk); lap = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #5;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk(irq, 1'b0, "R1 reset irq");
    chk(renew, 1'b0, "R1 reset renew");
    chk(carry, 1'b0, "R1 reset carry");
    @(negedge clk);
    rd_nib(2'd0, 4'd0, "R1 reset low nibble");

    ticks(37);
    rd_nib(2'd0, dig(37, 0), "R1 low digit");
    rd_nib(2'd1, dig(37, 1), "R6 middle digit");
    rd_nib(2'd2, dig(37, 2), "R6 top digit");
    rd_nib(2'd3, 4'd0, "R6 address 3");

    rd_nib(2'd0, dig(37, 0), "R6 low before freeze");
    ticks(5);
    rd_nib(2'd1, 4'd3, "R6 shadow frozen middle");
    rd_nib(2'd2, 4'd0, "R6 shadow frozen top");

    ticks(57);
    #5; chk(irq, 1'b0, "R2 no irq at 99");
    ticks(1);
    #5; chk(irq, 1'b1, "R2 irq on seconds carry");

    clr = 1'b1; tick = 1'b1; @(negedge clk); clr = 1'b0; tick = 1'b0; cnt = 0;
    #5; chk(irq, 1'b1, "R3 clear keeps irq");
    rd_nib(2'd0, 4'd0, "R3 clear zeroes low");
    rd_nib(2'd1, 4'd0, "R3 clear zeroes middle");
    rd_nib(2'd2, 4'd0, "R3 clear zeroes top");

    ack = 1'b1; @(negedge clk); ack = 1'b0;
    #5; chk(irq, 1'b0, "R4 ack clears irq");

    ticks(23);
    pulse_lap();
    ticks(11);
    rd_nib(2'd0, 4'd3, "R5 held low");
    rd_nib(2'd1, 4'd2, "R5 held middle");
    rd_nib(2'd2, 4'd0, "R5 held top");
    #5; chk(renew, 1'b0, "R7 lap before sequence");
    @(negedge clk);
    rd_nib(2'd0, dig(cnt, 0), "R5 released to live");
    rd_nib(2'd1, dig(cnt, 1), "R5 live middle");
    rd_nib(2'd2, dig(cnt, 2), "R5 live top");

    rd_nib(2'd0, dig(34, 0), "R7 sequence start");
    pulse_lap();
    rd_nib(2'd1, 4'd3, "R7 middle from shadow");
    rd_nib(2'd2, 4'd0, "R7 top from shadow");
    #5; chk(renew, 1'b1, "R7 renew set by lap in sequence");
    @(negedge clk);
    rd_nib(2'd0, dig(34, 0), "R5 renewed buffer kept");
    #5; chk(renew, 1'b0, "R7 renew cleared by low read");
    @(negedge clk);
    rd_nib(2'd1, 4'd3, "R6 renewed middle");
    rd_nib(2'd2, 4'd0, "R6 renewed top");

    pulse_lap();
    #5; chk(carry, 1'b0, "R8 no carry without pending");
    @(negedge clk);
    ticks(100 - cnt);
    #5; chk(irq, 1'b1, "R2 second carry");
    @(negedge clk);
    pulse_lap();
    #5; chk(carry, 1'b1, "R8 carry with pending irq");
    @(negedge clk);
    cclr = 1'b1; @(negedge clk); cclr = 1'b0;
    #5; chk(carry, 1'b0, "R9 write one clears carry");
    @(negedge clk);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    ticks(99);
    #5; chk(irq, 1'b0, "R4 acked before carry");
    @(negedge clk);
    tick = 1'b1; lap = 1'b1; @(negedge clk); tick = 1'b0; lap = 1'b0;
    cnt = (cnt + 1) % 1000;
    #5; chk(carry, 1'b1, "R8 lap same cycle as carry");
    chk(irq, 1'b1, "R2 carry at 199");
    @(negedge clk);
    ack = 1'b1; cclr = 1'b1; @(negedge clk); ack = 1'b0; cclr = 1'b0;

    clr = 1'b1; lap = 1'b1; @(negedge clk); clr = 1'b0; lap = 1'b0; cnt = 0;
    ticks(5);
    rd_nib(2'd0, 4'd5, "R3 clear beats lap");
    rd_nib(2'd1, 4'd0, "R3 clear middle");
    rd_nib(2'd2, 4'd0, "R3 clear top");
    #5; chk(carry, 1'b0, "R3 clear blocks lap carry");
    @(negedge clk);

    ticks(994);
    rd_nib(2'd0, 4'd9, "R1 999 low");
    rd_nib(2'd1, 4'd9, "R1 999 middle");
    rd_nib(2'd2, 4'd9, "R1 999 top");
    ticks(1);
    rd_nib(2'd0, 4'd0, "R1 wrap low");
    rd_nib(2'd1, 4'd0, "R1 wrap middle");
    rd_nib(2'd2, 4'd0, "R1 wrap top");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule